// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This combinational block is the hazard logic of a five-stage in-order integer pipeline. For each of the two ALU operands of the instruction in the execute stage, it chooses where the operand comes from: the register file, the memory-stage result or the writeback-stage result. It does this by comparing that operand's source register number with the destination numbers and write flags of the two later pipeline registers. It also detects a load that is followed at once by an instruction that reads the loaded register. In that case it holds the PC and the fetch/decode register and puts a bubble into the decode/execute register for one cycle.

Branches are resolved in decode and are predicted not taken. When decode reports a taken branch, the block flushes the instruction that has already been fetched. If a flush and a stall are requested in the same cycle, the flush wins.

The register file writes in the first half of the cycle and reads in the second half. For that reason the block never forwards from writeback to the decode stage, and decode-stage source numbers never affect the operand selects.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (memory-stage result) when the memory-stage write flag is set, its destination is nonzero, and that destination equals the operand's execute-stage source.
- R2: An operand select is 2'b01 (writeback-stage result) when the writeback-stage write flag is set, its destination is nonzero and equals the operand's source, and the R1 condition does not hold.
- R3: When both the memory stage and the writeback stage match the same operand, the select is 2'b10.
- R4: In every other case the select is 2'b00 (register file). This includes a destination of register 0 and a cleared write flag.
- R5: Operand 1's select depends only on execute source 1, and operand 2's select depends only on execute source 2.
- R6: When the execute-stage instruction is a load and its destination equals either decode source, hold_pc, hold_ifid and bubble_idex are all 1.
- R7: When the execute-stage instruction is not a load, or its destination matches neither decode source, hold_pc, hold_ifid and bubble_idex are all 0.
- R8: flush_ifid equals the decode-stage branch-taken input.
- R9: When a branch is taken, hold_pc, hold_ifid and bubble_idex are 0 even if R6 holds.
- R10: Decode-stage source numbers have no effect on either operand select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src1 | input | REG_AW | First source register of the decode-stage instruction |
| id_src2 | input | REG_AW | Second source register of the decode-stage instruction |
| ex_src1 | input | REG_AW | First source register held in decode/execute |
| ex_src2 | input | REG_AW | Second source register held in decode/execute |
| ex_dst | input | REG_AW | Destination held in decode/execute |
| ex_is_load | input | 1 | Memory-read flag held in decode/execute |
| mem_dst | input | REG_AW | Destination held in execute/memory |
| mem_wr_en | input | 1 | Register-write flag held in execute/memory |
| wb_dst | input | REG_AW | Destination held in memory/writeback |
| wb_wr_en | input | 1 | Register-write flag held in memory/writeback |
| id_br_taken | input | 1 | Branch resolved taken in decode |
| fwd_sel1 | output | 2 | Operand 1 source: 00 file, 10 memory stage, 01 writeback |
| fwd_sel2 | output | 2 | Operand 2 source, same encoding |
| hold_pc | output | 1 | Keep the PC unchanged |
| hold_ifid | output | 1 | Keep fetch/decode unchanged |
| bubble_idex | output | 1 | Load a no-op into decode/execute |
| flush_ifid | output | 1 | Clear the fetch/decode slot |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench applies each input pattern on the falling clock edge and samples the outputs 2 ns later, well before the next rising edge, so each check sees settled values for exactly one pattern. With 2-bit register numbers, the bench sweeps every combination of source, destinations and write flags for the forwarding selects. It then sweeps every combination of decode sources, load destination, load flag and branch flag for the stall and flush outputs.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_wr_en,
  input  logic [AW-1:0] wb_dst,
  output fwd_sel_e      sel
);
  logic mem_hit;
  logic wb_hit;

  assign mem_hit = mem_wr_en && (mem_dst != '0) && (mem_dst == src);
  assign wb_hit  = wb_wr_en  && (wb_dst  != '0) && (wb_dst  == src);

  // newer result wins
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_src1,
  input  logic [AW-1:0] id_src2,
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  output logic          hazard
);
  assign hazard = ex_is_load && ((ex_dst == id_src1) || (ex_dst == id_src2));
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl (
  input  logic hazard,
  input  logic br_taken,
  output logic hold_pc,
  output logic hold_ifid,
  output logic bubble_idex,
  output logic flush_ifid
);
  logic stall;

  // redirect overrides a stall request
  assign stall       = hazard && !br_taken;
  assign hold_pc     = stall;
  assign hold_ifid   = stall;
  assign bubble_idex = stall;
  assign flush_ifid  = br_taken;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_AW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [REG_AW-1:0] id_src1,
  input  logic [REG_AW-1:0] id_src2,
  input  logic [REG_AW-1:0] ex_src1,
  input  logic [REG_AW-1:0] ex_src2,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  input  logic              id_br_taken,
  output logic [1:0]        fwd_sel1,
  output logic [1:0]        fwd_sel2,
  output logic              hold_pc,
  output logic              hold_ifid,
  output logic              bubble_idex,
  output logic              flush_ifid
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] op_src [NUM_OPS];
  fwd_sel_e          op_sel [NUM_OPS];
  logic              lu_hazard;

  assign op_src[0] = ex_src1;
  assign op_src[1] = ex_src2;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_select #(.AW(REG_AW)) u_sel (
      .src       (op_src[g]),
      .mem_wr_en (mem_wr_en),
      .mem_dst   (mem_dst),
      .wb_wr_en  (wb_wr_en),
      .wb_dst    (wb_dst),
      .sel       (op_sel[g])
    );
  end

  assign fwd_sel1 = op_sel[0];
  assign fwd_sel2 = op_sel[1];

  load_use_detect #(.AW(REG_AW)) u_lu (
    .id_src1    (id_src1),
    .id_src2    (id_src2),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .hazard     (lu_hazard)
  );

  flow_ctrl u_flow (
    .hazard      (lu_hazard),
    .br_taken    (id_br_taken),
    .hold_pc     (hold_pc),
    .hold_ifid   (hold_ifid),
    .bubble_idex (bubble_idex),
    .flush_ifid  (flush_ifid)
  );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_src1,
  input logic [AW-1:0] id_src2,
  input logic [AW-1:0] ex_src1,
  input logic [AW-1:0] ex_src2,
  input logic [AW-1:0] ex_dst,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wr_en,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wr_en,
  input logic          id_br_taken,
  input logic [1:0]    fwd_sel1,
  input logic [1:0]    fwd_sel2,
  input logic          hold_pc,
  input logic          hold_ifid,
  input logic          bubble_idex,
  input logic          flush_ifid
);
  always_comb begin
    p_mem_fwd_r1: assert (!(mem_wr_en && mem_dst != '0 && mem_dst == ex_src1) || fwd_sel1 == 2'b10);
    p_wb_fwd_r2: assert (!(wb_wr_en && wb_dst != '0 && wb_dst == ex_src2 &&
                          !(mem_wr_en && mem_dst != '0 && mem_dst == ex_src2)) || fwd_sel2 == 2'b01);
    p_idle_sel_r4: assert (mem_wr_en || wb_wr_en || (fwd_sel1 == 2'b00 && fwd_sel2 == 2'b00));
    p_stall_group_r6: assert (hold_pc == hold_ifid && hold_ifid == bubble_idex);
    p_no_load_r7: assert (ex_is_load || !hold_pc);
    p_flush_r8: assert (flush_ifid == id_br_taken);
    p_flush_wins_r9: assert (!(flush_ifid && (hold_pc || bubble_idex)));
  end
  logic unused_ok;
  assign unused_ok = ^{id_src1, id_src2, ex_dst};
endmodule

bind hazard_unit hazard_unit_chk #(.AW(REG_AW)) chk_i (
  .id_src1(id_src1), .id_src2(id_src2), .ex_src1(ex_src1), .ex_src2(ex_src2),
  .ex_dst(ex_dst), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
  .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .id_br_taken(id_br_taken),
  .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2), .hold_pc(hold_pc), .hold_ifid(hold_ifid),
  .bubble_idex(bubble_idex), .flush_ifid(flush_ifid)
);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
  localparam int NR = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_src1, id_src2, ex_src1, ex_src2, ex_dst, mem_dst, wb_dst;
  logic ex_is_load, mem_wr_en, wb_wr_en, id_br_taken;
  logic [1:0] fwd_sel1, fwd_sel2;
  logic hold_pc, hold_ifid, bubble_idex, flush_ifid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  hazard_unit #(.NUM_REGS(NR)) dut_i (
    .id_src1(id_src1), .id_src2(id_src2), .ex_src1(ex_src1), .ex_src2(ex_src2),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .id_br_taken(id_br_taken),
    .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2), .hold_pc(hold_pc), .hold_ifid(hold_ifid),
    .bubble_idex(bubble_idex), .flush_ifid(flush_ifid)
  );

  function automatic logic [1:0] exp_sel(int src, int mw, int md, int ww, int wd);
    if (mw != 0 && md != 0 && md == src) return 2'b10;
    if (ww != 0 && wd != 0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string sel_req(logic [1:0] e, bit both);
    if (e == 2'b10) return both ? "R3" : "R1";
    if (e == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic idle();
    id_src1 = '0; id_src2 = '0; ex_src1 = '0; ex_src2 = '0; ex_dst = '0;
    mem_dst = '0; wb_dst = '0; ex_is_load = 0; mem_wr_en = 0; wb_wr_en = 0;
    id_br_taken = 0;
  endtask

  initial begin
    idle();
    @(negedge clk); #2;
    chk("R4 quiet sel1", fwd_sel1, 0);
    chk("R4 quiet sel2", fwd_sel2, 0);
    chk("R7 quiet hold", {hold_pc, hold_ifid, bubble_idex}, 0);
    chk("R8 quiet flush", flush_ifid, 0);

    // forwarding sweep: R1 R2 R3 R4 R5 R10
    for (int s = 0; s < NR; s++)
      for (int md = 0; md < NR; md++)
        for (int wd = 0; wd < NR; wd++)
          for (int mw = 0; mw < 2; mw++)
            for (int ww = 0; ww < 2; ww++) begin
              logic [1:0] e1, e2;
              bit b1, b2;
              int s2;
              s2 = (s + 1) % NR;
              @(negedge clk);
              ex_src1 = AW'(s); ex_src2 = AW'(s2);
              mem_dst = AW'(md); wb_dst = AW'(wd);
              mem_wr_en = mw[0]; wb_wr_en = ww[0];
              id_src1 = AW'(wd); id_src2 = AW'(md);  // R10: decode sources vary freely
              #2;
              e1 = exp_sel(s, mw, md, ww, wd);
              e2 = exp_sel(s2, mw, md, ww, wd);
              b1 = (exp_sel(s, 0, md, ww, wd) == 2'b01) && e1 == 2'b10;
              b2 = (exp_sel(s2, 0, md, ww, wd) == 2'b01) && e2 == 2'b10;
              chk({sel_req(e1, b1), " R5 sel1"}, fwd_sel1, e1);
              chk({sel_req(e2, b2), " R5 sel2"}, fwd_sel2, e2);
            end

    // R10 directed: decode sources match producers, execute sources do not
    @(negedge clk);
    idle();
    ex_src1 = 2'd3; ex_src2 = 2'd3; id_src1 = 2'd1; id_src2 = 2'd2;
    mem_dst = 2'd1; mem_wr_en = 1; wb_dst = 2'd2; wb_wr_en = 1;
    #2;
    chk("R10 sel1", fwd_sel1, 0);
    chk("R10 sel2", fwd_sel2, 0);

    // stall / flush sweep: R6 R7 R8 R9
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int d = 0; d < NR; d++)
          for (int ld = 0; ld < 2; ld++)
            for (int br = 0; br < 2; br++) begin
              bit hz;
              int eh;
              @(negedge clk);
              idle();
              id_src1 = AW'(a); id_src2 = AW'(b); ex_dst = AW'(d);
              ex_is_load = ld[0]; id_br_taken = br[0];
              #2;
              hz = (ld != 0) && (d == a || d == b);
              eh = (hz && br == 0) ? 7 : 0;
              if (br != 0)
                chk("R9 flush beats stall", {hold_pc, hold_ifid, bubble_idex}, 0);
              else if (hz)
                chk("R6 load-use stall", {hold_pc, hold_ifid, bubble_idex}, eh);
              else
                chk("R7 no stall", {hold_pc, hold_ifid, bubble_idex}, eh);
              chk("R8 flush", flush_ifid, br);
            end

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule